// File: doc/BRIEF.md
# Byte-Wide Load Port Receiver

This block is the receiving end of a byte-parallel load interface. It runs on a clock supplied by the sender. A byte on the 8-bit bus is taken on a rising edge when three things hold: select is low, write is low, and the busy flag is low. The sender must keep a byte on the bus for as long as busy is high. An internal stall generator raises busy for a programmable number of cycles after every Nth accepted byte, so the sender is throttled in a predictable way.

Bus line 0 carries the most significant bit of each byte. Bytes therefore leave the block bit-reversed, as a one-cycle valid strobe with the byte beside it. After reset, and again after every abort, the block is out of alignment. In that state it watches the accepted bytes for the 32-bit word 0xAA995566 and forwards nothing. Once the word has been seen, every accepted byte is forwarded.

An abort happens when the sender releases write while select stays low. The block pulses an abort flag, holds busy for a fixed recovery time, and then starts hunting for the sync word again. A load may be split into several bursts by raising select between them. A gap of this kind does not lose alignment.

Top module: `cfg_byte_load`

## Requirements
- R1: A byte is accepted at a rising edge where cs_ni=0, wr_ni=0 and busy_o=0. If the block is aligned, byte_valid_o is high and byte_o holds the byte during the cycle after that edge.
- R2: At an edge where cs_ni=1, no byte is accepted and no abort starts, whatever wr_ni and data_i are. byte_valid_o and abort_o are both low after such an edge.
- R3: A byte presented while busy_o=1 is not taken. The same bus value is taken once, at the first edge where busy_o=0, and produces exactly one output byte.
- R4: An edge with cs_ni=0 and wr_ni=1 starts an abort if the previous edge had cs_ni=0 and wr_ni=0. abort_o is then high for exactly the one cycle after that edge.
- R5: After an abort edge, busy_o is high for exactly ABORT_CYCLES cycles (default 4), counted from and including the abort_o cycle. It is then low.
- R6: After reset and after an abort, no byte is forwarded until the logical bytes AA, 99, 55 and 66 (hex, after bit reversal) are accepted in that order. The sync bytes themselves are not forwarded.
- R7: Bit order is reversed: byte_o[i] = data_i[7-i].
- R8: Accepted bytes are counted from reset or from the last abort, sync bytes included. After the edge that accepts byte number k*STALL_EVERY (default 4), busy_o is high for STALL_CYCLES cycles (default 2). An abort cancels a running stall.
- R9: Raising cs_ni and wr_ni together ends a burst without an abort. A later burst continues with the alignment and byte count already held.
- R10: While reset is asserted and right after it, busy_o, byte_valid_o and abort_o are low and the block is unaligned.
- R11: The sync search slides one byte at a time, so a repeated leading byte (AA AA 99 55 66) still aligns the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Load clock from the sender |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low |
| wr_ni | input | 1 | Write, active low |
| data_i | input | 8 | Byte bus, line 0 is the MSB |
| busy_o | output | 1 | Hold-off to the sender |
| byte_valid_o | output | 1 | Forwarded byte strobe |
| byte_o | output | 8 | Forwarded byte, MSB first |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
The hardest case to reach is an abort that lands on a stall. Write must be released at the very edge where the stall generator is already holding busy high. That requires an exact count of accepted bytes from the ports, with the sync bytes included. The bench keeps its own byte count and stall budget. It drives bytes until the count reaches a multiple of STALL_EVERY and releases write at the next edge. It then checks that busy lasts the abort length rather than the stall length, and that alignment has been lost.

// File: rtl/cfg_byte_load_pkg.sv
package cfg_byte_load_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYNC_W = 32;
  localparam logic [SYNC_W-1:0] SYNC_WORD = 32'hAA995566;
endpackage

// File: rtl/cfg_load_stall.sv
module cfg_load_stall #(
  parameter int unsigned EVERY  = 4,
  parameter int unsigned CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic clear_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(EVERY + 1);
  localparam int unsigned SC_W  = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EVERY - 1);

  logic [CNT_W-1:0] byte_cnt_q;
  logic [SC_W-1:0]  stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt_q <= '0;
      stall_q    <= '0;
    end else if (clear_i) begin
      byte_cnt_q <= '0;
      stall_q    <= '0;
    end else if (accept_i) begin
      if (byte_cnt_q == LAST) begin
        byte_cnt_q <= '0;
        stall_q    <= SC_W'(CYCLES);
      end else begin
        byte_cnt_q <= byte_cnt_q + 1'b1;
      end
    end else if (stall_q != '0) begin
      stall_q <= stall_q - 1'b1;
    end
  end

  assign busy_o = (stall_q != '0);

  AST_STALL_AFTER_NTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !clear_i && byte_cnt_q == LAST && CYCLES > 0) |=> busy_o); // R8
  AST_NO_ACCEPT_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accept_i); // R3
endmodule

// File: rtl/cfg_load_align.sv
module cfg_load_align
  import cfg_byte_load_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              clear_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              aligned_o
);
  logic [SYNC_W-1:0] win_q;
  logic [SYNC_W-1:0] win_next;
  logic              aligned_q;

  assign win_next = {win_q[SYNC_W-BYTE_W-1:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      aligned_q <= 1'b0;
    end else if (clear_i) begin
      win_q     <= '0;
      aligned_q <= 1'b0;
    end else if (accept_i && !aligned_q) begin
      win_q <= win_next;
      if (win_next == SYNC_WORD) aligned_q <= 1'b1;
    end
  end

  assign aligned_o = aligned_q;

  AST_ALIGN_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> $past(accept_i)); // R6
  AST_DROP_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !aligned_o); // R6
endmodule

// File: rtl/cfg_load_abort.sv
module cfg_load_abort #(
  parameter int unsigned ABORT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic wr_ni,
  output logic start_o,
  output logic active_o
);
  localparam int unsigned CW = $clog2(ABORT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(ABORT_CYCLES - 1);

  logic          prev_wr_q;
  logic          active_q;
  logic [CW-1:0] cnt_q;

  // abort: write released under select after a write edge
  assign start_o = !cs_ni && wr_ni && prev_wr_q && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_wr_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      prev_wr_q <= !cs_ni && !wr_ni;
      if (start_o) begin
        active_q <= 1'b1;
        cnt_q    <= LOAD;
      end else if (active_q) begin
        if (cnt_q == '0) active_q <= 1'b0;
        else             cnt_q    <= cnt_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;

  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cnt_q != '0) |=> active_o); // R5
  AST_ABORT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cnt_q == '0) |=> !active_o); // R5
  AST_START_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !cs_ni); // R2
endmodule

// File: rtl/cfg_byte_load.sv
module cfg_byte_load
  import cfg_byte_load_pkg::*;
#(
  parameter int unsigned STALL_EVERY  = 4,
  parameter int unsigned STALL_CYCLES = 2,
  parameter int unsigned ABORT_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              abort_o
);
  logic              accept;
  logic              abort_start;
  logic              abort_active;
  logic              stall_busy;
  logic              aligned;
  logic [BYTE_W-1:0] data_rev;
  logic              valid_q;
  logic [BYTE_W-1:0] byte_q;
  logic              abort_q;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign data_rev[g] = data_i[BYTE_W-1-g];
  end

  assign busy_o = abort_active || stall_busy;
  assign accept = !cs_ni && !wr_ni && !busy_o;

  cfg_load_abort #(.ABORT_CYCLES(ABORT_CYCLES)) u_abort (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .wr_ni   (wr_ni),
    .start_o (abort_start),
    .active_o(abort_active)
  );

  cfg_load_stall #(.EVERY(STALL_EVERY), .CYCLES(STALL_CYCLES)) u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .clear_i (abort_start),
    .busy_o  (stall_busy)
  );

  cfg_load_align u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .clear_i  (abort_start),
    .byte_i   (data_rev),
    .aligned_o(aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      valid_q <= accept && aligned;
      abort_q <= abort_start;
      if (accept && aligned) byte_q <= data_rev;
    end
  end

  assign byte_valid_o = valid_q;
  assign byte_o       = byte_q;
  assign abort_o      = abort_q;

  AST_CS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!byte_valid_o && !abort_o)); // R2
  AST_NO_TAKE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !byte_valid_o); // R3
  AST_VALID_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(!cs_ni && !wr_ni)); // R1
  AST_ABORT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(!cs_ni && wr_ni)); // R4
  AST_ABORT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> busy_o); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R4
endmodule

// File: tb/cfg_byte_load_bench.sv
module cfg_byte_load_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int STALL_EVERY  = 4;
  localparam int STALL_CYCLES = 2;
  localparam int ABORT_CYCLES = 4;
  localparam logic [31:0] SYNC = 32'hAA995566;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic       busy, valid, abrt;
  logic [7:0] bout;

  int total = 0;
  int failed = 0;
  bit aligned = 0;
  logic [31:0] win = '0;
  int acc = 0;
  int pending = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_load #(.STALL_EVERY(STALL_EVERY), .STALL_CYCLES(STALL_CYCLES),
                  .ABORT_CYCLES(ABORT_CYCLES)) u_cfg_byte_load (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .data_i(data),
    .busy_o(busy), .byte_valid_o(valid), .byte_o(bout), .abort_o(abrt)
  );

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] lb);
    int nb = 0;
    cs_n = 1'b0; wr_n = 1'b0; data = rev8(lb);
    while (busy && nb < 64) begin
      if (nb > 0) chk(!valid, "R3", "valid during hold-off", valid, 0);
      nb++;
      @(negedge clk);
    end
    chk(nb == pending, "R8", "stall cycles before byte", nb, pending);
    pending = 0;
    @(negedge clk);
    acc++;
    if (aligned) begin
      chk(valid, "R1", "byte strobe", valid, 1);
      chk(bout == lb, "R7", "reversed byte", bout, lb);
    end else begin
      chk(!valid, "R6", "no output while unaligned", valid, 0);
      win = {win[23:0], lb};
      if (win == SYNC) aligned = 1;
    end
    if (acc % STALL_EVERY == 0) pending = STALL_CYCLES;
  endtask

  task automatic idle(input int n);
    cs_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      wr_n = i[0];
      data = 8'(i * 37 + 5);
      @(negedge clk);
      chk(!valid && !abrt, "R2", "activity with select high", {valid, abrt}, 0);
    end
    pending = (pending > n) ? pending - n : 0;
  endtask

  task automatic do_abort();
    int nb = 0;
    wr_n = 1'b1;
    @(negedge clk);
    chk(abrt, "R4", "abort pulse", abrt, 1);
    chk(!valid, "R4", "no byte on abort", valid, 0);
    while (busy && nb < 64) begin
      if (nb == 1) chk(!abrt, "R4", "abort pulse width", abrt, 0);
      nb++;
      @(negedge clk);
    end
    chk(nb == ABORT_CYCLES, "R5", "abort busy length", nb, ABORT_CYCLES);
    aligned = 0; win = '0; acc = 0; pending = 0;
  endtask

  task automatic send_sync();
    send(8'hAA); send(8'h99); send(8'h55); send(8'h66);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failed++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !valid && !abrt, "R10", "outputs in reset", {busy, valid, abrt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid && !abrt, "R10", "outputs after reset", {busy, valid, abrt}, 0);
    idle(3);
    send(8'h12); send(8'h34);           // R6 unaligned
    send_sync();
    chk(aligned, "R6", "model aligned after sync", aligned, 1);
    for (int v = 0; v < 256; v++) begin  // R7 sweep, bursts R9
      send(8'(v));
      if (v % 37 == 36) idle(v % 5 + 1);
    end
    do_abort();
    send(8'h5A); send(8'h66);           // R6 discarded
    send(8'hAA); send(8'hAA); send(8'h99); send(8'h55); send(8'h66); // R11
    chk(aligned, "R11", "sliding sync", aligned, 1);
    send(8'hC3);
    // R9: select and write rise together
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk(!abrt, "R9", "no abort on joint release", abrt, 0);
    pending = (pending > 1) ? pending - 1 : 0;
    idle(2);
    cs_n = 1'b0; wr_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!abrt && !valid, "R9", "select low without write", {abrt, valid}, 0);
    end
    pending = (pending > 2) ? pending - 2 : 0;
    send(8'h81);
    send(8'h7E);
    // abort on top of a stall
    while (acc % STALL_EVERY != 0) send(8'(acc + 8'h40));
    chk(busy, "R8", "stall running before abort", busy, 1);
    do_abort();
    send(8'h77);
    chk(!aligned, "R6", "unaligned after abort in stall", aligned, 0);
    send_sync();
    send(8'h0F); send(8'hF0);
    do_abort();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule